// File: doc/BRIEF.md
# Color Subcarrier Phase Accumulator

This block is the numerically controlled oscillator that supplies the chroma subcarrier phase to a composite video encoder. It runs from a fixed 108 MHz video clock. Every clock it adds a 32-bit phase increment to a 32-bit accumulator, and the sum wraps at 2^32. The increment is one of two built-in words, one for NTSC and one for PAL. A custom 32-bit word can replace both of them. That word is computed for exactly 108 MHz, since no fractional clock division is allowed.

Software programs the block through a small write port with a 2-bit address. One register holds the standard select and the custom enable. One holds an 8-bit start phase, where a value v means 360·v/256 degrees. Two registers hold the upper and lower 16-bit halves of the custom word. A line or field sync pulse reloads the accumulator from the start phase. The encoder reads two outputs: the full phase word, and a truncated address for a sine lookup.

The upper and lower halves are written separately. A two-state write tracker makes the new word take effect only when the lower half is written:

- In `S_IDLE`, no upper half is waiting. A write of the upper half stages it and moves the tracker to `S_HALF`.
- In `S_HALF`, an upper half is staged. A write of the lower half commits the staged upper half together with the new lower half, and returns the tracker to `S_IDLE`.
- A write of the lower half in `S_IDLE` keeps the active upper half and stays in `S_IDLE`.
- A soft reset or a reset forces the tracker to `S_IDLE`.

Top module: `subcarrier_nco`

## Requirements
- R1: After `rst_n` is low, `phase_word` is 0. The registers then hold these values: NTSC selected, custom word disabled, start phase 0x28, custom word 0x223B61D1.
- R2: On each clock edge without reload or soft reset, `phase_word` becomes its old value plus the active increment, modulo 2^32. With NTSC selected and the custom word disabled, the increment is 0x087C1F08.
- R3: A write to address 0 takes `wr_data[0]` as the standard select, where 1 means PAL. With PAL selected and the custom word disabled, the increment is 0x0A8262B9.
- R4: `wr_data[1]` of a write to address 0 is the custom enable. When it is 1, the active custom word is the increment, whatever the standard select holds.
- R5: When `sync_reload` is high at an edge, `phase_word` becomes the start phase in bits 31:24 with bits 23:0 cleared. No increment is added on that edge.
- R6: A write to address 2 stages the upper half of the custom word and leaves the active increment unchanged. The next write to address 3 makes {staged upper, new lower} active, both halves at once.
- R7: A write to address 3 with no upper half staged makes {current active upper, new lower} the active custom word.
- R8: When `soft_rst` is high at an edge, `phase_word` is cleared and every register returns to its R1 value. This overrides a reload and a write in the same cycle.
- R9: `lut_addr` always equals `phase_word[31:22]`.
- R10: A write to address 1 sets the start phase to `wr_data[7:0]`. A later reload uses that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 108 MHz video clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear of the accumulator and all registers |
| sync_reload | input | 1 | Line or field sync pulse that reloads the phase |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 start phase, 2 upper half, 3 lower half |
| wr_data | input | 16 | Register write data |
| phase_word | output | 32 | Current accumulator value |
| lut_addr | output | 10 | Truncated phase for the sine lookup |

## Verification
Each stimulus lands on the clock edge after it is driven. A reload, a soft reset, an accumulate step or a register write changes state on that edge. A register write changes only the increment, so it first shows in `phase_word` one edge later still. The bench drives inputs just after a falling edge and compares the outputs at the next falling edge. Its reference model follows that same one-edge update order.

// File: rtl/snco_pkg.sv
package snco_pkg;
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_HALF = 1'b1
    } wr_state_e;

    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_PHASE = 2'd1;
    localparam logic [1:0] A_FHI   = 2'd2;
    localparam logic [1:0] A_FLO   = 2'd3;
endpackage

// File: rtl/snco_regs.sv
module snco_regs
    import snco_pkg::*;
#(
    parameter int              ACC_W    = 32,
    parameter int              PH_W     = 8,
    parameter logic [ACC_W-1:0] CUST_DEF = 32'h223B_61D1,
    parameter logic [PH_W-1:0]  PH_DEF   = 8'h28,
    localparam int             HALF_W   = ACC_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    output logic              sel_pal,
    output logic              sel_cust,
    output logic [PH_W-1:0]   start_ph,
    output logic [ACC_W-1:0]  cust_word,
    output wr_state_e         state
);
    wr_state_e         state_n;
    logic [HALF_W-1:0] stage_hi;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state <= S_IDLE;
        else if (soft_rst) state <= S_IDLE;
        else               state <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        if (wr_en) begin
            unique case (wr_addr)
                A_FHI:   state_n = S_HALF;
                A_FLO:   state_n = S_IDLE;
                default: state_n = state;
            endcase
        end
    end

    // Register outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_pal   <= 1'b0;
            sel_cust  <= 1'b0;
            start_ph  <= PH_DEF;
            stage_hi  <= CUST_DEF[ACC_W-1:HALF_W];
            cust_word <= CUST_DEF;
        end else if (soft_rst) begin
            sel_pal   <= 1'b0;
            sel_cust  <= 1'b0;
            start_ph  <= PH_DEF;
            stage_hi  <= CUST_DEF[ACC_W-1:HALF_W];
            cust_word <= CUST_DEF;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CTRL: begin
                    sel_pal  <= wr_data[0];
                    sel_cust <= wr_data[1];
                end
                A_PHASE: start_ph <= wr_data[PH_W-1:0];
                A_FHI:   stage_hi <= wr_data;
                A_FLO: begin
                    unique case (state)
                        S_HALF: cust_word <= {stage_hi, wr_data};
                        S_IDLE: cust_word <= {cust_word[ACC_W-1:HALF_W], wr_data};
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/snco_accum.sv
module snco_accum #(
    parameter int               ACC_W    = 32,
    parameter int               PH_W     = 8,
    parameter logic [ACC_W-1:0] NTSC_INC = 32'h087C_1F08,
    parameter logic [ACC_W-1:0] PAL_INC  = 32'h0A82_62B9,
    localparam int              LOW_W    = ACC_W - PH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             reload,
    input  logic             sel_pal,
    input  logic             sel_cust,
    input  logic [PH_W-1:0]  start_ph,
    input  logic [ACC_W-1:0] cust_word,
    output logic [ACC_W-1:0] acc,
    output logic [ACC_W-1:0] inc
);
    always_comb begin
        if (sel_cust)     inc = cust_word;
        else if (sel_pal) inc = PAL_INC;
        else              inc = NTSC_INC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        acc <= '0;
        else if (soft_rst) acc <= '0;
        else if (reload)   acc <= {start_ph, {LOW_W{1'b0}}};
        else               acc <= acc + inc;
    end
endmodule

// File: rtl/subcarrier_nco.sv
module subcarrier_nco
    import snco_pkg::*;
#(
    parameter int               ACC_W    = 32,
    parameter int               PH_W     = 8,
    parameter int               LUT_W    = 10,
    parameter logic [ACC_W-1:0] NTSC_INC = 32'h087C_1F08,
    parameter logic [ACC_W-1:0] PAL_INC  = 32'h0A82_62B9,
    parameter logic [ACC_W-1:0] CUST_DEF = 32'h223B_61D1,
    parameter logic [PH_W-1:0]  PH_DEF   = 8'h28,
    localparam int              HALF_W   = ACC_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              sync_reload,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    output logic [ACC_W-1:0]  phase_word,
    output logic [LUT_W-1:0]  lut_addr
);
    logic             sel_pal;
    logic             sel_cust;
    logic [PH_W-1:0]  start_q;
    logic [ACC_W-1:0] cust_word;
    logic [ACC_W-1:0] inc_active;
    wr_state_e        wr_state;

    snco_regs #(
        .ACC_W(ACC_W), .PH_W(PH_W), .CUST_DEF(CUST_DEF), .PH_DEF(PH_DEF)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sel_pal(sel_pal), .sel_cust(sel_cust), .start_ph(start_q),
        .cust_word(cust_word), .state(wr_state)
    );

    snco_accum #(
        .ACC_W(ACC_W), .PH_W(PH_W), .NTSC_INC(NTSC_INC), .PAL_INC(PAL_INC)
    ) u_accum (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reload(sync_reload),
        .sel_pal(sel_pal), .sel_cust(sel_cust), .start_ph(start_q),
        .cust_word(cust_word), .acc(phase_word), .inc(inc_active)
    );

    assign lut_addr = phase_word[ACC_W-1 -: LUT_W];
endmodule

// File: rtl/snco_checker.sv
module snco_checker
    import snco_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        soft_rst,
    input logic        sync_reload,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [31:0] phase_word,
    input logic [31:0] inc_active,
    input logic [7:0]  start_q,
    input wr_state_e   wr_state
);
    p_accumulate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && !sync_reload) |=> phase_word == $past(phase_word + inc_active));

    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && sync_reload) |=> phase_word == {$past(start_q), 24'h0});

    p_hi_no_effect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && wr_en && wr_addr == A_FHI) |=> $stable(inc_active));

    p_hi_stages_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && wr_en && wr_addr == A_FHI) |=> wr_state == S_HALF);

    p_soft_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (phase_word == 32'h0 && start_q == 8'h28 && wr_state == S_IDLE));
endmodule

bind subcarrier_nco snco_checker u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sync_reload(sync_reload),
    .wr_en(wr_en), .wr_addr(wr_addr), .phase_word(phase_word),
    .inc_active(inc_active), .start_q(start_q), .wr_state(wr_state)
);

// File: tb/subcarrier_nco_bench.sv
module subcarrier_nco_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        sync_reload = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [31:0] phase_word;
    logic [9:0]  lut_addr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    string tag = "R1";

    subcarrier_nco u_subcarrier_nco (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sync_reload(sync_reload),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .phase_word(phase_word), .lut_addr(lut_addr)
    );

    always #10 clk = ~clk;

    // Reference model built from the requirements
    logic        m_pal, m_cust, m_pend;
    logic [7:0]  m_phase;
    logic [15:0] m_hi;
    logic [31:0] m_word, m_acc;

    function automatic logic [31:0] m_inc();
        if (m_cust)     return m_word;
        else if (m_pal) return 32'h0A82_62B9;
        else            return 32'h087C_1F08;
    endfunction

    task automatic m_defaults();
        m_pal = 1'b0; m_cust = 1'b0; m_pend = 1'b0; m_phase = 8'h28;
        m_hi = 16'h223B; m_word = 32'h223B_61D1; m_acc = 32'h0;
    endtask

    always @(posedge clk) begin
        if (!rst_n || soft_rst) m_defaults();
        else begin
            m_acc = sync_reload ? {m_phase, 24'h0} : m_acc + m_inc();
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin m_pal = wr_data[0]; m_cust = wr_data[1]; end
                    2'd1: m_phase = wr_data[7:0];
                    2'd2: begin m_hi = wr_data; m_pend = 1'b1; end
                    default: begin
                        m_word = {(m_pend ? m_hi : m_word[31:16]), wr_data};
                        m_pend = 1'b0;
                    end
                endcase
            end
        end
    end

    task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        check(tag, phase_word, m_acc);
        check("R9", {22'h0, lut_addr}, {22'h0, m_acc[31:22]});
        wr_en = 1'b0; sync_reload = 1'b0; soft_rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
    endtask

    task automatic pulse_reload();
        sync_reload = 1'b1;
        step();
    endtask

    initial begin
        m_defaults();
        repeat (3) @(negedge clk);
        check("R1", phase_word, 32'h0);
        rst_n = 1'b1;
        tag = "R2"; step(); check("R2", phase_word, 32'h087C_1F08);
        step(); step();
        tag = "R5"; pulse_reload(); check("R5", phase_word, 32'h2800_0000);
        tag = "R2"; step(); check("R2", phase_word, 32'h2800_0000 + 32'h087C_1F08);
        tag = "R3"; wr(2'd0, 16'h0001); step(); step();
        tag = "R4"; wr(2'd0, 16'h0003); pulse_reload(); step();
        check("R4", phase_word, 32'h2800_0000 + 32'h223B_61D1);
        tag = "R6"; wr(2'd2, 16'h1234); step(); step();
        wr(2'd3, 16'h5678); pulse_reload(); step();
        check("R6", phase_word, 32'h2800_0000 + 32'h1234_5678);
        tag = "R7"; wr(2'd3, 16'h0001); pulse_reload(); step();
        check("R7", phase_word, 32'h2800_0000 + 32'h1234_0001);
        tag = "R10"; wr(2'd1, 16'h0000); wr(2'd2, 16'hFFFF); wr(2'd3, 16'hFFFF);
        pulse_reload(); check("R10", phase_word, 32'h0);
        tag = "R2"; step(); check("R2", phase_word, 32'hFFFF_FFFF);
        step(); check("R2", phase_word, 32'hFFFF_FFFE);
        tag = "R8"; soft_rst = 1'b1; sync_reload = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'h00AA;
        step(); check("R8", phase_word, 32'h0);
        tag = "R8"; step(); check("R8", phase_word, 32'h087C_1F08);
        tag = "R8"; pulse_reload(); check("R8", phase_word, 32'h2800_0000);
        tag = "R2";
        void'($urandom(32'd7));
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 20) begin
                wr_en = 1'b1; wr_addr = 2'($urandom_range(0, 3));
                wr_data = 16'($urandom);
            end
            if (r >= 20 && r < 26) sync_reload = 1'b1;
            if (r == 99) soft_rst = 1'b1;
            step();
        end
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule